// File: doc/BRIEF.md
# Three-Wire Dual Wiper Register Slave

This block is the digital control section of a dual 256-step potentiometer. A host talks to it over three wires: an enable line that frames a transaction, a serial clock and a serial data line. While the enable is high, each rising serial clock edge shifts one data bit into a 17-bit staging register. The register holds a stack-select bit and two 8-bit wiper codes. When the enable is released, the staged values are copied into the active wiper registers that drive the block's outputs. The active values never move in the middle of a transaction.

The bit leaving the far end of the staging register is always present on a cascade output, whatever the enable level. Several blocks can therefore be chained, with the cascade output of one feeding the data input of the next. When the cascade output is looped back to the data input, 17 clocks rotate the register back to its starting contents, so the host can read the settings without changing them. A stacked output selects one of the two wiper codes according to the stack-select bit. A 9-bit position output joins the stack-select bit to the selected code, for use when the two halves are wired in series.

All three port inputs are asynchronous to the system clock. Each is brought in through a synchronizer chain, and the edges of the serial clock and the enable are detected in the system clock domain.

Top module: `pot3w_ctrl`

## Requirements
- R1: After synchronous reset, both wiper codes are 8'h80, the stack-select bit is 0, and the staging register holds that same setting, so the cascade output is 0.
- R2: While the enable is low, serial clock edges and data values leave the staging register unchanged. A later release of the enable with no clocks commits the earlier contents.
- R3: A frame is 17 bits sent in this order: stack select, then wiper-1 MSB first, then wiper-0 MSB first. Once shifted in, staging bit 0 is stack select, bits 1..8 are wiper-1 with its MSB at bit 1, and bits 9..16 are wiper-0 with its MSB at bit 9.
- R4: While the enable is high, the wiper codes and the stack-select output do not change.
- R5: When the enable goes from high to low, the staging register is copied into the active wiper codes and the stack-select bit.
- R6: The cascade output is staging bit 0. Each shift moves the register one place toward bit 0, so the first bit out of a transaction is the stack-select bit of the previous contents.
- R7: The cascade output stays valid while the enable is low.
- R8: The stacked code equals wiper-0 when stack select is 0 and wiper-1 when it is 1. The 9-bit position output is {stack select, stacked code}.
- R9: If a transaction shifts a count of bits that is not a multiple of 17, the partly shifted register is still committed when the enable falls.
- R10: With the cascade output fed back to the data input, 17 clocks restore the original staging contents, and the commit that follows leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Transaction enable, asynchronous; high opens a transaction |
| port_clk | input | 1 | Serial clock, asynchronous; a rising edge shifts one bit |
| port_din | input | 1 | Serial data input, asynchronous |
| cascade_out | output | 1 | Bit at the far end of the staging register |
| wiper0_code | output | 8 | Active wiper-0 code |
| wiper1_code | output | 8 | Active wiper-1 code |
| stack_sel | output | 1 | Active stack-select bit |
| stack_code | output | 8 | Wiper code selected by stack select |
| stack_pos | output | 9 | {stack_sel, stack_code} |

## Verification
With two synchronizer stages, a rising serial clock becomes a shift on the third system clock edge after it. The cascade output moves on that same edge. A falling enable commits on the third edge after it, and the wiper, stack and position outputs move on that same edge. The bench holds every port level for four system clocks and checks the cascade output only after the serial clock low phase. It checks the commit results six clocks after the enable falls, at a falling system clock edge, so each result is read after it is due and before the next stimulus can disturb it. The mid-transaction checks for R4 are taken while the enable is still high, after several bits have been shifted in.

// File: rtl/pot3w_pkg.sv
package pot3w_pkg;

    parameter int WIPER_W = 8;
    localparam int FRAME_W = 2 * WIPER_W + 1;
    localparam logic [WIPER_W-1:0] WIPER_MID = WIPER_W'(1) << (WIPER_W - 1);

    typedef struct packed {
        logic [WIPER_W-1:0] w0;
        logic [WIPER_W-1:0] w1;
        logic               ss;
    } wiper_set_t;

    // staging bit 0 = ss, bits 1.. = w1 msb first, then w0 msb first
    function automatic wiper_set_t frame_to_set(input logic [FRAME_W-1:0] f);
        wiper_set_t s;
        s.ss = f[0];
        for (int i = 0; i < WIPER_W; i++) begin
            s.w1[WIPER_W-1-i] = f[1+i];
            s.w0[WIPER_W-1-i] = f[1+WIPER_W+i];
        end
        return s;
    endfunction

    function automatic logic [FRAME_W-1:0] set_to_frame(input wiper_set_t s);
        logic [FRAME_W-1:0] f;
        f[0] = s.ss;
        for (int i = 0; i < WIPER_W; i++) begin
            f[1+i]         = s.w1[WIPER_W-1-i];
            f[1+WIPER_W+i] = s.w0[WIPER_W-1-i];
        end
        return f;
    endfunction

    localparam wiper_set_t RESET_SET = '{w0: WIPER_MID, w1: WIPER_MID, ss: 1'b0};

endpackage

// File: rtl/pot3w_sync.sv
module pot3w_sync #(
    parameter int STAGES = 2,
    parameter int LANES  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] async_in,
    output logic [LANES-1:0] level
);

    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], async_in[ln]};
            end
            assign level[ln] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pot3w_shifter.sv
module pot3w_shifter
    import pot3w_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               shift,
    input  logic               din,
    output logic [FRAME_W-1:0] sreg,
    output logic               cout
);

    always_ff @(posedge clk) begin
        if (rst)        sreg <= set_to_frame(RESET_SET);
        else if (shift) sreg <= {din, sreg[FRAME_W-1:1]};
    end

    assign cout = sreg[0];

    AST_SHIFT_OUT: assert property (@(posedge clk) disable iff (rst)
        shift |=> cout == $past(sreg[1]));   // R6

endmodule

// File: rtl/pot3w_commit.sv
module pot3w_commit
    import pot3w_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  logic [FRAME_W-1:0] frame,
    output wiper_set_t         active,
    output logic [WIPER_W-1:0] sel_code,
    output logic [WIPER_W:0]   sel_pos
);

    always_ff @(posedge clk) begin
        if (rst)         active <= RESET_SET;
        else if (commit) active <= frame_to_set(frame);
    end

    always_comb begin
        sel_code = active.ss ? active.w1 : active.w0;
        sel_pos  = {active.ss, sel_code};
    end

    AST_LOAD_W1_MSB: assert property (@(posedge clk) disable iff (rst)
        commit |=> active.w1[WIPER_W-1] == $past(frame[1]));   // R3
    AST_LOAD_W0_LSB: assert property (@(posedge clk) disable iff (rst)
        commit |=> active.w0[0] == $past(frame[FRAME_W-1]));   // R5
    AST_STACK_PICK: assert property (@(posedge clk) disable iff (rst)
        commit |=> sel_code == ($past(frame[0]) ? active.w1 : active.w0));   // R8

endmodule

// File: rtl/pot3w_ctrl.sv
module pot3w_ctrl
    import pot3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               port_en,
    input  logic               port_clk,
    input  logic               port_din,
    output logic               cascade_out,
    output logic [WIPER_W-1:0] wiper0_code,
    output logic [WIPER_W-1:0] wiper1_code,
    output logic               stack_sel,
    output logic [WIPER_W-1:0] stack_code,
    output logic [WIPER_W:0]   stack_pos
);

    localparam int LN_EN  = 0;
    localparam int LN_CLK = 1;
    localparam int LN_DIN = 2;

    logic [2:0]         sync_lv;
    logic               en_s, sclk_s, din_s;
    logic               en_prev, sclk_prev;
    logic               sclk_rise, en_fall, do_shift;
    logic [FRAME_W-1:0] sreg;
    wiper_set_t         active;

    pot3w_sync #(.STAGES(SYNC_STAGES), .LANES(3)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in ({port_din, port_clk, port_en}),
        .level    (sync_lv)
    );

    assign en_s   = sync_lv[LN_EN];
    assign sclk_s = sync_lv[LN_CLK];
    assign din_s  = sync_lv[LN_DIN];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_prev   <= 1'b0;
            sclk_prev <= 1'b0;
        end else begin
            en_prev   <= en_s;
            sclk_prev <= sclk_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_prev;
    assign en_fall   = ~en_s & en_prev;
    assign do_shift  = sclk_rise & en_s;

    pot3w_shifter shift_i (
        .clk   (clk),
        .rst   (rst),
        .shift (do_shift),
        .din   (din_s),
        .sreg  (sreg),
        .cout  (cascade_out)
    );

    pot3w_commit commit_i (
        .clk      (clk),
        .rst      (rst),
        .commit   (en_fall),
        .frame    (sreg),
        .active   (active),
        .sel_code (stack_code),
        .sel_pos  (stack_pos)
    );

    assign wiper0_code = active.w0;
    assign wiper1_code = active.w1;
    assign stack_sel   = active.ss;

    AST_RESET_MID: assert property (@(posedge clk)
        rst |=> (wiper0_code == WIPER_MID && wiper1_code == WIPER_MID && !stack_sel));   // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> $stable(sreg));   // R2
    AST_TXN_STABLE: assert property (@(posedge clk) disable iff (rst)
        en_s |=> $stable({wiper0_code, wiper1_code, stack_sel}));   // R4
    AST_POS_TOP: assert property (@(posedge clk) disable iff (rst)
        en_fall |=> stack_pos[WIPER_W] == $past(sreg[0]));   // R8

endmodule

// File: tb/pot3w_ctrl_tb.sv
module pot3w_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_en = 1'b0;
    logic       port_clk = 1'b0;
    logic       port_din = 1'b0;
    logic       cascade_out;
    logic [7:0] wiper0_code, wiper1_code, stack_code;
    logic       stack_sel;
    logic [8:0] stack_pos;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [16:0] m_sreg;
    logic [7:0]  m_w0, m_w1;
    logic        m_ss;

    always #10 clk = ~clk;

    pot3w_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .port_en     (port_en),
        .port_clk    (port_clk),
        .port_din    (port_din),
        .cascade_out (cascade_out),
        .wiper0_code (wiper0_code),
        .wiper1_code (wiper1_code),
        .stack_sel   (stack_sel),
        .stack_code  (stack_code),
        .stack_pos   (stack_pos)
    );

    function automatic logic [7:0] fr_w1(input logic [16:0] f);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = f[1+i];
        return r;
    endfunction

    function automatic logic [7:0] fr_w0(input logic [16:0] f);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = f[9+i];
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_active(input string tag);
        check({tag, " wiper0"}, wiper0_code, m_w0);
        check({tag, " wiper1"}, wiper1_code, m_w1);
        check({tag, " stack_sel"}, stack_sel, m_ss);
        check({tag, " R8 stack_code"}, stack_code, m_ss ? m_w1 : m_w0);
        check({tag, " R8 stack_pos"}, stack_pos, {m_ss, m_ss ? m_w1 : m_w0});
    endtask

    task automatic open_txn();
        port_en = 1'b1;
        wait_clk(4);
    endtask

    task automatic close_txn(input string tag);
        port_en = 1'b0;
        wait_clk(6);
        m_w0 = fr_w0(m_sreg);
        m_w1 = fr_w1(m_sreg);
        m_ss = m_sreg[0];
        check_active(tag);
        check({tag, " R7 cascade after release"}, cascade_out, m_sreg[0]);
    endtask

    task automatic send_bit(input logic b);
        port_din = b;
        wait_clk(4);
        port_clk = 1'b1;
        wait_clk(4);
        port_clk = 1'b0;
        wait_clk(4);
        m_sreg = {b, m_sreg[16:1]};
        check("R6 cascade after shift", cascade_out, m_sreg[0]);
    endtask

    task automatic send_frame(input logic ss, input logic [7:0] w1, input logic [7:0] w0,
                              input bit mid_check);
        logic [16:0] bits;
        bits = {w0[0], w0[1], w0[2], w0[3], w0[4], w0[5], w0[6], w0[7],
                w1[0], w1[1], w1[2], w1[3], w1[4], w1[5], w1[6], w1[7], ss};
        for (int i = 0; i < 17; i++) begin
            send_bit(bits[i]);
            if (mid_check && i == 8) check_active("R4 mid-transaction");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);

        m_sreg = 17'h00202;
        m_w0 = 8'h80;
        m_w1 = 8'h80;
        m_ss = 1'b0;
        check_active("R1 reset");
        check("R1 reset cascade", cascade_out, 0);

        // R3 R5 directed frame, first bits out are the old stack select (R6)
        open_txn();
        send_frame(1'b1, 8'h3C, 8'hA5, 1'b1);
        close_txn("R3 R5 directed");
        check("R3 wiper1 field", wiper1_code, 8'h3C);
        check("R3 wiper0 field", wiper0_code, 8'hA5);

        // R2: clocks with enable low are ignored
        for (int i = 0; i < 10; i++) begin
            port_din = 1'($urandom);
            wait_clk(4);
            port_clk = 1'b1;
            wait_clk(4);
            port_clk = 1'b0;
            wait_clk(4);
            check("R2 idle cascade", cascade_out, m_sreg[0]);
        end
        open_txn();
        close_txn("R2 empty commit");
        check("R2 wiper0 kept", wiper0_code, 8'hA5);

        // corner codes
        open_txn();
        send_frame(1'b0, 8'hFF, 8'h00, 1'b0);
        close_txn("R8 ss0 corner");
        open_txn();
        send_frame(1'b1, 8'h00, 8'hFF, 1'b0);
        close_txn("R8 ss1 corner");

        // random frames
        for (int k = 0; k < 12; k++) begin
            open_txn();
            send_frame(1'($urandom), 8'($urandom), 8'($urandom), k < 3);
            close_txn("R5 random");
        end

        // R9 partial frames: 5 bits, then 20 bits
        open_txn();
        for (int i = 0; i < 5; i++) send_bit(1'($urandom));
        close_txn("R9 partial 5");
        open_txn();
        for (int i = 0; i < 20; i++) send_bit(1'($urandom));
        close_txn("R9 partial 20");

        // two frames in one transaction: last one stays
        open_txn();
        send_frame(1'b0, 8'h11, 8'h22, 1'b0);
        send_frame(1'b1, 8'h5A, 8'hC3, 1'b0);
        close_txn("R3 double frame");
        check("R3 double wiper1", wiper1_code, 8'h5A);

        // R10 loopback readback, twice
        for (int rep = 0; rep < 2; rep++) begin
            logic [16:0] orig;
            logic [7:0]  o0, o1;
            logic        os;
            orig = m_sreg;
            o0 = wiper0_code;
            o1 = wiper1_code;
            os = stack_sel;
            open_txn();
            for (int i = 0; i < 17; i++) send_bit(cascade_out);
            check("R10 model restored", m_sreg, orig);
            close_txn("R10 loopback commit");
            check("R10 wiper0 unchanged", wiper0_code, o0);
            check("R10 wiper1 unchanged", wiper1_code, o1);
            check("R10 stack_sel unchanged", stack_sel, os);
            open_txn();
            send_frame(1'($urandom), 8'($urandom), 8'($urandom), 1'b0);
            close_txn("R10 reload");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule